// File: doc/BRIEF.md
# Low-Power Stop Mode Controller

This block sequences a small microcontroller into and out of its deepest power-saving state. When the CPU executes its stop instruction it raises a one-cycle request together with the address of that instruction. If the stop-enable option bit is set, the controller closes the CPU and peripheral clock gates, puts the regulator into standby, freezes the I/O pin levels and turns the internal oscillator off unless software asked for it to stay on. If the option bit is clear, the controller does not stop. It raises a one-cycle illegal-opcode reset request instead.

While the device is stopped, three kinds of event can end the state: the external reset pin, any asynchronous interrupt line whose enable bit is set, and the periodic wake timer. The reset pin and the interrupt lines are synchronised through two flops before they are used. A wake produces a one-cycle pulse, a resume address and a latched cause word that software can read afterwards. The clock gates reopen from registers one cycle after the pulse. The wake timer counts ticks from either a slow self-clocked source or a trimmed reference. The trimmed reference keeps counting during stop only if both low-voltage enable bits were set when stop was entered.

Top module: `lpstop_ctrl`

## Requirements
- R1: When `stop_req` is sampled high while running and `opt_stop_en` is 1, `cpu_clk_en` and `per_clk_en` are both 0 from the next cycle on.
- R2: When `stop_req` is sampled high while running and `opt_stop_en` is 0, `illop_rst` is 1 for exactly one cycle, and both clock enables stay 1.
- R3: While stopped, `reg_standby` is 1 and `osc_en` equals the value `opt_osc_keep` had when stop was entered. While running, `reg_standby` is 0 and `osc_en` is 1.
- R4: `io_hold` is 1 for every cycle in which the clock enables are 0, and 0 while running.
- R5: A wake happens only because of `ext_rst_req`, an `irq_async[i]` with `irq_en[i]` = 1, or the wake timer. An interrupt whose enable bit is 0 leaves the block stopped. `wake` rises on the third clock edge after a wake input goes high, and `wake` is never 1 while the clocks run.
- R6: On a reset-pin wake, `resume_pc` is 0x3FFD. On an interrupt or timer wake, it is the captured `stop_pc` plus 1, modulo 2^PCW.
- R7: `wake_cause` uses this bit layout: bit i = interrupt i (0 keyboard, 1 low voltage, 2 comparator), bit 3 = wake timer, bit 4 = reset pin. A reset-pin wake reports only bit 4, because the reset pin takes priority. The word holds its value until the next wake.
- R8: The clock enables return to 1 together, exactly one cycle after the `wake` pulse, and never rise without a preceding `wake` pulse.
- R9: With `rti_sel` = 0 the wake timer never wakes. With `rti_sel` = s > 0 it wakes on the 2^s-th tick of the selected source, counted from stop entry.
- R10: With `rti_ref_sel` = 0 the timer counts `tick_slow`. With `rti_ref_sel` = 1 it counts `tick_ref`, and only if `lv_en` and `lv_stop_en` were both 1 at stop entry.
- R11: After reset: clock enables 1, `osc_en` 1, `reg_standby` 0, `io_hold` 0, `illop_rst` 0, `wake` 0, `wake_cause` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running base clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_req | input | 1 | One-cycle stop instruction strobe from the CPU |
| stop_pc | input | PCW | Address of the stop instruction |
| opt_stop_en | input | 1 | Option bit that permits stop |
| opt_osc_keep | input | 1 | Keep the internal oscillator running in stop |
| lv_en | input | 1 | Low-voltage detector enable |
| lv_stop_en | input | 1 | Low-voltage detector enable during stop |
| rti_sel | input | RSW | Wake timer period select, 0 = off |
| rti_ref_sel | input | 1 | Timer source: 0 slow self-clocked, 1 trimmed reference |
| tick_slow | input | 1 | Tick strobe of the slow source |
| tick_ref | input | 1 | Tick strobe of the trimmed reference |
| ext_rst_req | input | 1 | External reset pin, asynchronous |
| irq_async | input | NSRC | Asynchronous interrupt lines |
| irq_en | input | NSRC | Per-line wake enables |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| reg_standby | output | 1 | Regulator standby request |
| osc_en | output | 1 | Internal oscillator enable |
| io_hold | output | 1 | Freeze I/O pin levels and state |
| illop_rst | output | 1 | Illegal-opcode reset request |
| wake | output | 1 | One-cycle wake pulse |
| resume_pc | output | PCW | Address execution resumes at |
| wake_cause | output | NSRC+2 | Latched cause of the last wake |

## Verification
The bench builds the block with its defaults: three interrupt lines, a 14-bit address and a 3-bit timer select. With these values every enable mask can be combined with every interrupt line, and every timer period, up to 128 ticks, can be run from both tick sources. The sweep therefore covers each line both enabled and disabled, and checks the exact tick on which the timer wakes. It also exercises the reset-pin exit after each wake that is expected to be suppressed.

// File: rtl/lpstop_pkg.sv
package lpstop_pkg;
    localparam int NSRC_DEF = 3;
    localparam int PCW_DEF  = 14;
    localparam int RSW_DEF  = 3;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_STOP   = 2'd1,
        ST_RESUME = 2'd2
    } lp_state_e;

    // Settings frozen at the moment stop is entered
    typedef struct packed {
        logic               osc_keep;
        logic               lv_ok;
        logic               ref_sel;
        logic [RSW_DEF-1:0] sel;
    } lp_cfg_t;

    // Last counter value of a timer period of 2^sel ticks
    function automatic logic [2**RSW_DEF-1:0] rti_last(input logic [RSW_DEF-1:0] sel);
        logic [2**RSW_DEF-1:0] one;
        one = 1;
        return (one << sel) - one;
    endfunction
endpackage

// File: rtl/lpstop_sync.sv
module lpstop_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta;
        logic stab;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta <= 1'b0;
                stab <= 1'b0;
            end else begin
                meta <= din[g];
                stab <= meta;
            end
        end
        assign dout[g] = stab;
    end
endmodule

// File: rtl/lpstop_rti.sv
module lpstop_rti
    import lpstop_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    active,
    input  lp_cfg_t cfg,
    input  logic    tick_slow,
    input  logic    tick_ref,
    output logic    fire
);
    localparam int CW = 2**RSW_DEF;

    logic [CW-1:0] cnt;
    logic          tick;
    logic [CW-1:0] last;

    always_comb begin
        last = rti_last(cfg.sel);
        if (cfg.sel == '0)
            tick = 1'b0;
        else if (cfg.ref_sel)
            tick = tick_ref & cfg.lv_ok;
        else
            tick = tick_slow;
    end

    always_ff @(posedge clk) begin
        if (rst || !active)
            cnt <= '0;
        else if (tick)
            cnt <= (cnt == last) ? '0 : cnt + 1'b1;
    end

    assign fire = active & tick & (cnt == last);
endmodule

// File: rtl/lpstop_seq.sv
module lpstop_seq
    import lpstop_pkg::*;
#(
    parameter int               NSRC      = NSRC_DEF,
    parameter int               PCW       = PCW_DEF,
    parameter logic [PCW-1:0]   RESET_VEC = 14'h3FFD
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                stop_req,
    input  logic [PCW-1:0]      stop_pc,
    input  logic                opt_stop_en,
    input  lp_cfg_t             cfg_in,
    input  logic [NSRC-1:0]     irq_s,
    input  logic [NSRC-1:0]     irq_en,
    input  logic                pin_s,
    input  logic                rti_fire,
    output lp_cfg_t             cfg_q,
    output logic                stopped,
    output logic                gate_en,
    output logic                standby,
    output logic                hold,
    output logic                osc_on,
    output logic                illop,
    output logic                wake,
    output logic [PCW-1:0]      resume_pc,
    output logic [NSRC+1:0]     cause
);
    lp_state_e       state;
    logic [PCW-1:0]  pc_q;
    logic [NSRC-1:0] hit;

    assign hit     = irq_s & irq_en;
    assign stopped = (state == ST_STOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_RUN;
            gate_en   <= 1'b1;
            standby   <= 1'b0;
            hold      <= 1'b0;
            osc_on    <= 1'b1;
            illop     <= 1'b0;
            wake      <= 1'b0;
            resume_pc <= '0;
            cause     <= '0;
            pc_q      <= '0;
            cfg_q     <= '0;
        end else begin
            illop <= 1'b0;
            wake  <= 1'b0;
            unique case (state)
                ST_RUN: begin
                    if (stop_req) begin
                        if (opt_stop_en) begin
                            state   <= ST_STOP;
                            gate_en <= 1'b0;
                            standby <= 1'b1;
                            hold    <= 1'b1;
                            osc_on  <= cfg_in.osc_keep;
                            cfg_q   <= cfg_in;
                            pc_q    <= stop_pc;
                        end else begin
                            illop <= 1'b1;
                        end
                    end
                end
                ST_STOP: begin
                    if (pin_s) begin
                        state     <= ST_RESUME;
                        wake      <= 1'b1;
                        osc_on    <= 1'b1;
                        resume_pc <= RESET_VEC;
                        cause     <= {1'b1, 1'b0, {NSRC{1'b0}}};
                    end else if ((|hit) || rti_fire) begin
                        state     <= ST_RESUME;
                        wake      <= 1'b1;
                        osc_on    <= 1'b1;
                        resume_pc <= pc_q + 1'b1;
                        cause     <= {1'b0, rti_fire, hit};
                    end
                end
                ST_RESUME: begin
                    state   <= ST_RUN;
                    gate_en <= 1'b1;
                    standby <= 1'b0;
                    hold    <= 1'b0;
                end
                default: state <= ST_RUN;
            endcase
        end
    end
endmodule

// File: rtl/lpstop_ctrl.sv
module lpstop_ctrl
    import lpstop_pkg::*;
#(
    parameter int             NSRC      = NSRC_DEF,
    parameter int             PCW       = PCW_DEF,
    parameter int             RSW       = RSW_DEF,
    parameter logic [PCW-1:0] RESET_VEC = 14'h3FFD
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            stop_req,
    input  logic [PCW-1:0]  stop_pc,
    input  logic            opt_stop_en,
    input  logic            opt_osc_keep,
    input  logic            lv_en,
    input  logic            lv_stop_en,
    input  logic [RSW-1:0]  rti_sel,
    input  logic            rti_ref_sel,
    input  logic            tick_slow,
    input  logic            tick_ref,
    input  logic            ext_rst_req,
    input  logic [NSRC-1:0] irq_async,
    input  logic [NSRC-1:0] irq_en,
    output logic            cpu_clk_en,
    output logic            per_clk_en,
    output logic            reg_standby,
    output logic            osc_en,
    output logic            io_hold,
    output logic            illop_rst,
    output logic            wake,
    output logic [PCW-1:0]  resume_pc,
    output logic [NSRC+1:0] wake_cause
);
    localparam int SYW = NSRC + 1;

    logic [SYW-1:0]  sync_out;
    lp_cfg_t         cfg_now;
    lp_cfg_t         cfg_held;
    logic            stopped;
    logic            rti_fire;
    logic            gate_en;

    always_comb begin
        cfg_now.osc_keep = opt_osc_keep;
        cfg_now.lv_ok    = lv_en & lv_stop_en;
        cfg_now.ref_sel  = rti_ref_sel;
        cfg_now.sel      = rti_sel;
    end

    lpstop_sync #(.W(SYW)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({ext_rst_req, irq_async}),
        .dout (sync_out)
    );

    lpstop_rti u_rti (
        .clk       (clk),
        .rst       (rst),
        .active    (stopped),
        .cfg       (cfg_held),
        .tick_slow (tick_slow),
        .tick_ref  (tick_ref),
        .fire      (rti_fire)
    );

    lpstop_seq #(.NSRC(NSRC), .PCW(PCW), .RESET_VEC(RESET_VEC)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .stop_req    (stop_req),
        .stop_pc     (stop_pc),
        .opt_stop_en (opt_stop_en),
        .cfg_in      (cfg_now),
        .irq_s       (sync_out[NSRC-1:0]),
        .irq_en      (irq_en),
        .pin_s       (sync_out[NSRC]),
        .rti_fire    (rti_fire),
        .cfg_q       (cfg_held),
        .stopped     (stopped),
        .gate_en     (gate_en),
        .standby     (reg_standby),
        .hold        (io_hold),
        .osc_on      (osc_en),
        .illop       (illop_rst),
        .wake        (wake),
        .resume_pc   (resume_pc),
        .cause       (wake_cause)
    );

    assign cpu_clk_en = gate_en;
    assign per_clk_en = gate_en;
endmodule

// File: rtl/lpstop_chk.sv
module lpstop_chk #(
    parameter int             NSRC = 3,
    parameter int             PCW  = 14,
    parameter logic [PCW-1:0] RVEC = 14'h3FFD
) (
    input logic            clk,
    input logic            rst,
    input logic            stop_req,
    input logic            opt_stop_en,
    input logic            cpu_clk_en,
    input logic            per_clk_en,
    input logic            reg_standby,
    input logic            io_hold,
    input logic            illop_rst,
    input logic            wake,
    input logic [PCW-1:0]  resume_pc,
    input logic [NSRC+1:0] wake_cause
);
    AST_STOP_GATES: assert property (@(posedge clk) disable iff (rst)
        (cpu_clk_en && stop_req && opt_stop_en) |=> (!cpu_clk_en && !per_clk_en)); // R1
    AST_ILLOP_PULSE: assert property (@(posedge clk) disable iff (rst)
        (cpu_clk_en && stop_req && !opt_stop_en) |=> (illop_rst && cpu_clk_en)); // R2
    AST_STANDBY_STOP: assert property (@(posedge clk) disable iff (rst)
        !cpu_clk_en |-> reg_standby); // R3
    AST_HOLD_STOP: assert property (@(posedge clk) disable iff (rst)
        !cpu_clk_en |-> io_hold); // R4
    AST_WAKE_STOPPED: assert property (@(posedge clk) disable iff (rst)
        wake |-> !cpu_clk_en); // R5
    AST_RESET_VECTOR: assert property (@(posedge clk) disable iff (rst)
        (wake && wake_cause[NSRC+1]) |-> (resume_pc == RVEC)); // R6
    AST_CAUSE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!wake && !$past(rst)) |-> $stable(wake_cause)); // R7
    AST_REOPEN_AFTER_WAKE: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_clk_en) |-> $past(wake)); // R8
endmodule

bind lpstop_ctrl lpstop_chk #(.NSRC(NSRC), .PCW(PCW), .RVEC(RESET_VEC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .stop_req    (stop_req),
    .opt_stop_en (opt_stop_en),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .reg_standby (reg_standby),
    .io_hold     (io_hold),
    .illop_rst   (illop_rst),
    .wake        (wake),
    .resume_pc   (resume_pc),
    .wake_cause  (wake_cause)
);

// File: tb/lpstop_ctrl_tb.sv
module lpstop_ctrl_tb;
    localparam int NSRC = 3;
    localparam int PCW  = 14;
    localparam int RSW  = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            stop_req = 1'b0;
    logic [PCW-1:0]  stop_pc = '0;
    logic            opt_stop_en = 1'b0;
    logic            opt_osc_keep = 1'b0;
    logic            lv_en = 1'b0;
    logic            lv_stop_en = 1'b0;
    logic [RSW-1:0]  rti_sel = '0;
    logic            rti_ref_sel = 1'b0;
    logic            tick_slow = 1'b0;
    logic            tick_ref = 1'b0;
    logic            ext_rst_req = 1'b0;
    logic [NSRC-1:0] irq_async = '0;
    logic [NSRC-1:0] irq_en = '0;
    logic            cpu_clk_en, per_clk_en, reg_standby, osc_en, io_hold;
    logic            illop_rst, wake;
    logic [PCW-1:0]  resume_pc;
    logic [NSRC+1:0] wake_cause;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    lpstop_ctrl u_dut (
        .clk(clk), .rst(rst), .stop_req(stop_req), .stop_pc(stop_pc),
        .opt_stop_en(opt_stop_en), .opt_osc_keep(opt_osc_keep),
        .lv_en(lv_en), .lv_stop_en(lv_stop_en), .rti_sel(rti_sel),
        .rti_ref_sel(rti_ref_sel), .tick_slow(tick_slow), .tick_ref(tick_ref),
        .ext_rst_req(ext_rst_req), .irq_async(irq_async), .irq_en(irq_en),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .reg_standby(reg_standby), .osc_en(osc_en), .io_hold(io_hold),
        .illop_rst(illop_rst), .wake(wake), .resume_pc(resume_pc),
        .wake_cause(wake_cause)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    // Enter stop and check the stopped outputs (R1, R3, R4)
    task automatic enter_stop(input logic [PCW-1:0] pc, input logic keep);
        opt_stop_en  = 1'b1;
        opt_osc_keep = keep;
        stop_pc      = pc;
        stop_req     = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        check("R1 cpu gate closed", cpu_clk_en, 0);
        check("R1 per gate closed", per_clk_en, 0);
        check("R3 standby in stop", reg_standby, 1);
        check("R3 osc in stop", osc_en, keep);
        check("R4 hold in stop", io_hold, 1);
    endtask

    // After wake pulse was seen, check the reopen cycle (R8, R3, R4)
    task automatic check_reopen();
        @(negedge clk);
        check("R8 cpu gate reopened", cpu_clk_en, 1);
        check("R8 per gate reopened", per_clk_en, 1);
        check("R8 wake is a pulse", wake, 0);
        check("R3 standby off", reg_standby, 0);
        check("R3 osc on", osc_en, 1);
        check("R4 hold off", io_hold, 0);
    endtask

    // Reset-pin exit from stop with its timing (R5, R6, R7)
    task automatic pin_wake();
        ext_rst_req = 1'b1;
        idle(2);
        check("R5 pin not yet", wake, 0);
        @(negedge clk);
        ext_rst_req = 1'b0;
        check("R5 pin wake", wake, 1);
        check("R6 reset vector", resume_pc, 14'h3FFD);
        check("R7 reset cause", wake_cause, 5'b10000);
        check_reopen();
        idle(3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        check("R11 cpu gate", cpu_clk_en, 1);
        check("R11 per gate", per_clk_en, 1);
        check("R11 osc", osc_en, 1);
        check("R11 standby", reg_standby, 0);
        check("R11 hold", io_hold, 0);
        check("R11 illop", illop_rst, 0);
        check("R11 wake", wake, 0);
        check("R11 cause", wake_cause, 0);

        // R2: stop with option clear
        opt_stop_en = 1'b0;
        stop_req    = 1'b1;
        @(negedge clk);
        stop_req = 1'b0;
        check("R2 illop asserted", illop_rst, 1);
        check("R2 clocks keep running", cpu_clk_en, 1);
        check("R2 per keeps running", per_clk_en, 1);
        @(negedge clk);
        check("R2 illop one cycle", illop_rst, 0);
        check("R2 still running", cpu_clk_en, 1);

        // R5/R6/R7: every line against every enable mask
        for (int src = 0; src < NSRC; src++) begin
            for (int m = 0; m < (1 << NSRC); m++) begin
                logic [PCW-1:0] pc;
                pc = PCW'(14'h0F00 + src * 16 + m);
                if (src == 2 && m == 7) pc = 14'h3FFF;
                irq_en = NSRC'(m);
                enter_stop(pc, logic'(m[0]));
                irq_async[src] = 1'b1;
                idle(2);
                check("R5 no early wake", wake, 0);
                @(negedge clk);
                if (m[src]) begin
                    check("R5 enabled line wakes", wake, 1);
                    check("R5 gates still closed at pulse", cpu_clk_en, 0);
                    check("R6 resume after stop", resume_pc, PCW'(pc + 1));
                    check("R7 line cause", wake_cause, 5'(1 << src));
                    irq_async[src] = 1'b0;
                    check_reopen();
                    idle(3);
                end else begin
                    idle(3);
                    check("R5 disabled line ignored", wake, 0);
                    check("R5 stays stopped", cpu_clk_en, 0);
                    irq_async[src] = 1'b0;
                    idle(3);
                    pin_wake();
                end
            end
        end
        irq_en = '0;

        // R9/R10: every period on both sources
        for (int rs = 0; rs < 2; rs++) begin
            for (int s = 1; s < (1 << RSW); s++) begin
                int n;
                n = 1 << s;
                rti_sel     = RSW'(s);
                rti_ref_sel = logic'(rs);
                lv_en       = 1'b1;
                lv_stop_en  = 1'b1;
                enter_stop(PCW'(14'h0200 + s), 1'b0);
                for (int t = 1; t <= n; t++) begin
                    if (rs == 1) tick_ref = 1'b1; else tick_slow = 1'b1;
                    @(negedge clk);
                    tick_ref  = 1'b0;
                    tick_slow = 1'b0;
                    if (t == n) begin
                        check("R9 wake on last tick", wake, 1);
                        check("R7 timer cause", wake_cause, 5'b01000);
                        check("R6 timer resume", resume_pc, PCW'(14'h0200 + s + 1));
                    end else if (t == n - 1 || t == 1) begin
                        check("R9 no wake before period", wake, 0);
                    end
                    @(negedge clk);
                end
                check("R8 reopened after timer", cpu_clk_en, 1);
                idle(2);
            end
        end

        // R10: reference source with low-voltage bits incomplete
        for (int lv = 0; lv < 3; lv++) begin
            lv_en       = logic'(lv[0]);
            lv_stop_en  = logic'(lv[1]);
            rti_sel     = 3'd2;
            rti_ref_sel = 1'b1;
            enter_stop(14'h0300, 1'b1);
            for (int t = 0; t < 10; t++) begin
                tick_ref = 1'b1;
                @(negedge clk);
                tick_ref = 1'b0;
                @(negedge clk);
            end
            check("R10 reference frozen without both lv bits", wake, 0);
            check("R10 still stopped", cpu_clk_en, 0);
            pin_wake();
        end

        // R10: slow source selected, reference ticks do not count
        lv_en = 1'b1; lv_stop_en = 1'b1;
        rti_sel = 3'd1; rti_ref_sel = 1'b0;
        enter_stop(14'h0310, 1'b0);
        for (int t = 0; t < 6; t++) begin
            tick_ref = 1'b1;
            @(negedge clk);
            tick_ref = 1'b0;
            @(negedge clk);
        end
        check("R10 unselected source ignored", cpu_clk_en, 0);
        pin_wake();

        // R9: select 0 disables the timer
        rti_sel = '0;
        enter_stop(14'h0320, 1'b0);
        for (int t = 0; t < 20; t++) begin
            tick_slow = 1'b1;
            tick_ref  = 1'b1;
            @(negedge clk);
            tick_slow = 1'b0;
            tick_ref  = 1'b0;
            @(negedge clk);
        end
        check("R9 select zero never wakes", wake, 0);
        check("R9 select zero stays stopped", cpu_clk_en, 0);
        pin_wake();
        check("R7 cause held after wake", wake_cause, 5'b10000);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule